// File: doc/BRIEF.md
# Multiprocessor-Mode Serial Transmitter

This block is an asynchronous serial transmitter. Every character it sends carries one extra flag bit, which marks the character as an address or as data for receivers sharing one line. Software or a DMA engine loads a character together with its flag bit into a holding register. The block copies the holding register into a frame shifter when the shifter is idle, and it shifts the frame out one bit per pulse of an external bit-rate enable.

Two status flags report progress. The holding-empty flag shows that a new character may be written, and while the transmitter is enabled this flag also raises a transmit-empty request. The done flag shows that the line has gone quiet after the last stop bit. A DMA write clears the holding-empty flag in the same cycle as the write. A software write needs a separate clear strobe.

When the transmitter is disabled, the block hands the serial pin to a general-purpose port direction bit and a port data bit. Driving the pin as an output at 0 holds the line low as a break.

Top module: `mp_uart_tx`

## Requirements
- R1: After reset, the holding-empty flag is 1, the done flag is 1 and the transmit-empty request is 0. With the transmitter disabled and the port direction bit at 0, the serial pin is 1.
- R2: A software write (`wr_stb`) or a DMA write (`dma_wr`) is taken into the holding register only while the holding-empty flag is 1. A write made while the flag is 0 is ignored, and the character already held is the one sent.
- R3: `clr_empty` clears the holding-empty flag. When the transmitter is enabled, the shifter is idle and the flag is 0, the next clock edge starts the frame, sets the holding-empty flag back to 1 and clears the done flag.
- R4: A frame is sent in this order: a 0 start bit, then the 8 data bits with bit 0 first, then the flag bit, then a 1 stop bit. Each bit is held until one `bit_tick` pulse, and the line is 1 between frames.
- R5: `txi_req` is 1 exactly while the transmitter is enabled and the holding-empty flag is 1.
- R6: A DMA write accepted under R2 clears the holding-empty flag on the same clock edge, with no `clr_empty` strobe.
- R7: The `bit_tick` that ends a stop bit sets the done flag if the holding-empty flag is 1 at that edge. If a character is pending instead, the done flag stays 0 and the next frame starts one clock later.
- R8: While `tx_en` is 0, the serial pin equals `port_dat` when `port_dir` is 1 and equals 1 when `port_dir` is 0, so direction 1 with data 0 produces a break.
- R9: Clearing `tx_en` abandons any frame in progress. On the next edge both flags are set to 1, and the shifter is idle when `tx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | Single-cycle pulse, one per bit period |
| tx_en | input | 1 | Transmit enable; when 1, the serial output function owns the pin |
| wr_stb | input | 1 | Software write of the holding register |
| dma_wr | input | 1 | DMA write of the holding register, with automatic flag clear |
| wr_byte | input | 8 | Character to write |
| wr_mpb | input | 1 | Address/data flag bit sent with the character |
| clr_empty | input | 1 | Software clear of the holding-empty flag |
| port_dir | input | 1 | General-purpose port direction bit (1 = output) |
| port_dat | input | 1 | General-purpose port data bit |
| tx_pin | output | 1 | Serial line |
| empty_flag | output | 1 | Holding-empty flag |
| done_flag | output | 1 | Transmit-done flag |
| txi_req | output | 1 | Transmit-empty request |

## Verification
The assertions assume that `bit_tick` is a single-cycle pulse and that the inputs are steady around each rising clock edge. They place no limit on how writes, clears and ticks overlap. The bench drives every input at the falling edge and drops each tick after one cycle. It also places writes deliberately while the holding-empty flag is 0 and while a frame is running, so that the properties on ignored writes and on flag handover are exercised rather than avoided.

// File: rtl/mp_uart_tx.sv
module mp_uart_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          tx_en,
  input  logic          wr_stb,
  input  logic          dma_wr,
  input  logic [DW-1:0] wr_byte,
  input  logic          wr_mpb,
  input  logic          clr_empty,
  input  logic          port_dir,
  input  logic          port_dat,
  output logic          tx_pin,
  output logic          empty_flag,
  output logic          done_flag,
  output logic          txi_req
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(FW);

  logic [DW-1:0] hold_q;
  logic          hold_mp_q;
  logic [FW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, empty_q, done_q;

  wire accept = empty_q & (wr_stb | dma_wr);
  wire load   = tx_en & ~busy_q & ~empty_q;
  wire last   = busy_q & bit_tick & (cnt_q == CW'(FW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_mp_q <= 1'b0;
      sh_q      <= '1;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      empty_q   <= 1'b1;
      done_q    <= 1'b1;
    end else begin
      if (accept) begin
        hold_q    <= wr_byte;
        hold_mp_q <= wr_mpb;
      end
      if (!tx_en) begin
        busy_q  <= 1'b0;
        cnt_q   <= '0;
        empty_q <= 1'b1;
        done_q  <= 1'b1;
      end else if (load) begin
        sh_q    <= {1'b1, hold_mp_q, hold_q, 1'b0};
        cnt_q   <= '0;
        busy_q  <= 1'b1;
        empty_q <= 1'b1;
        done_q  <= 1'b0;
      end else begin
        if ((dma_wr && empty_q) || clr_empty) empty_q <= 1'b0;
        if (last) begin
          busy_q <= 1'b0;
          if (empty_q) done_q <= 1'b1;
        end else if (busy_q && bit_tick) begin
          cnt_q <= cnt_q + 1'b1;
          sh_q  <= {1'b1, sh_q[FW-1:1]};
        end
      end
    end
  end

  assign tx_pin     = tx_en ? (busy_q ? sh_q[0] : 1'b1) : (port_dir ? port_dat : 1'b1);
  assign empty_flag = empty_q;
  assign done_flag  = done_q;
  assign txi_req    = tx_en & empty_q;

  assert_ignored_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_q && (wr_stb || dma_wr)) |=> (hold_q == $past(hold_q) && hold_mp_q == $past(hold_mp_q)));
  assert_load_refills_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (empty_q && !done_q));
  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && busy_q && cnt_q == '0) |-> !tx_pin);
  assert_stop_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && busy_q && cnt_q == CW'(FW - 1)) |-> tx_pin);
  assert_dma_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && dma_wr && empty_q) |=> !empty_q);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!busy_q && empty_q && done_q));
endmodule

// File: tb/mp_uart_tx_tb.sv
module mp_uart_tx_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_tick = 0, tx_en = 0, wr_stb = 0, dma_wr = 0, wr_mpb = 0, clr_empty = 0;
  logic port_dir = 0, port_dat = 0;
  logic [7:0] wr_byte = '0;
  logic tx_pin, empty_flag, done_flag, txi_req;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mp_uart_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
    .wr_stb(wr_stb), .dma_wr(dma_wr), .wr_byte(wr_byte), .wr_mpb(wr_mpb),
    .clr_empty(clr_empty), .port_dir(port_dir), .port_dat(port_dat),
    .tx_pin(tx_pin), .empty_flag(empty_flag), .done_flag(done_flag), .txi_req(txi_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  task automatic put(input logic [7:0] d, input logic m);
    wr_byte = d; wr_mpb = m; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; clr_empty = 1'b1;
    @(negedge clk);
    clr_empty = 1'b0;
  endtask

  task automatic run_bits(input logic [7:0] d, input logic m, input logic exp_done);
    logic [10:0] fr;
    fr = {1'b1, m, d, 1'b0};
    check("R4 start bit", tx_pin, 0);
    for (int i = 1; i <= 10; i++) begin
      tick();
      check("R4 frame bit", tx_pin, fr[i]);
    end
    tick();
    check("R7 done after stop", done_flag, exp_done);
    check("R4 idle high", tx_pin, 1);
  endtask

  task automatic t_reset();
    check("R1 empty", empty_flag, 1);
    check("R1 done", done_flag, 1);
    check("R1 txi", txi_req, 0);
    check("R1 pin", tx_pin, 1);
  endtask

  task automatic t_frame(input logic [7:0] d, input logic m);
    put(d, m);
    check("R3 cleared", empty_flag, 0);
    check("R5 txi low", txi_req, 0);
    @(negedge clk);
    check("R3 refilled", empty_flag, 1);
    check("R3 done cleared", done_flag, 0);
    check("R5 txi high", txi_req, 1);
    run_bits(d, m, 1'b1);
  endtask

  task automatic t_ignored();
    put(8'h3C, 1'b1);
    wr_byte = 8'hFF; wr_mpb = 1'b0; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    run_bits(8'h3C, 1'b1, 1'b1);
    check("R2 no stray load", empty_flag, 1);
  endtask

  task automatic t_dma();
    wr_byte = 8'h96; wr_mpb = 1'b0; dma_wr = 1'b1;
    @(negedge clk);
    dma_wr = 1'b0;
    check("R6 auto clear", empty_flag, 0);
    @(negedge clk);
    run_bits(8'h96, 1'b0, 1'b1);
  endtask

  task automatic t_back_to_back();
    put(8'hA1, 1'b1);
    @(negedge clk);
    put(8'h5E, 1'b0);
    check("R7 pending", empty_flag, 0);
    run_bits(8'hA1, 1'b1, 1'b0);
    @(negedge clk);
    check("R7 next frame starts", tx_pin, 0);
    check("R7 done stays low", done_flag, 0);
    run_bits(8'h5E, 1'b0, 1'b1);
  endtask

  task automatic t_break_abort();
    put(8'h00, 1'b0);
    @(negedge clk);
    tick(); tick();
    port_dir = 1'b1; port_dat = 1'b0; tx_en = 1'b0;
    @(negedge clk);
    check("R9 empty set", empty_flag, 1);
    check("R9 done set", done_flag, 1);
    check("R8 break low", tx_pin, 0);
    check("R5 txi off", txi_req, 0);
    port_dat = 1'b1; #1;
    check("R8 port data high", tx_pin, 1);
    port_dir = 1'b0; port_dat = 1'b0; #1;
    check("R8 port input", tx_pin, 1);
    tx_en = 1'b1;
    @(negedge clk);
    check("R9 idle after re-enable", tx_pin, 1);
    tick();
    check("R9 no resume", tx_pin, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    tx_en = 1'b1;
    @(negedge clk);
    t_frame(8'hB5, 1'b1);
    t_frame(8'h4A, 1'b0);
    t_ignored();
    t_dma();
    t_back_to_back();
    t_break_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule